// File: doc/BRIEF.md
# Serial Port FIFO Control with Transmit Trigger

This block is the buffering and flow-control core that sits between software and the bit-level engine of an asynchronous serial port. It owns a transmit byte queue filled by software and drained by the serialiser, and a receive byte queue filled by the deserialiser and drained by software. Each queue keeps an occupancy count that software can read through a small register port. Software can also force either count to zero through a clear bit in the control register.

A two-bit trigger code selects the fill level at or below which a sticky "transmit space available" flag is raised. Software drops that flag only by first reading it as 1 and then writing 0, and the drop takes effect only while the transmit queue holds more bytes than the selected level. A modem-control enable bit governs the clear-to-send input and the request-to-send output. When the enable bit is off, both lines have fixed levels. When it is on, transmission waits on clear-to-send, and request-to-send warns the far end when the receive queue is nearly full. A loopback bit routes the transmit bit stream back into the receiver and feeds request-to-send into clear-to-send internally.

Register map (2-bit address): 0 = control, 1 = status, 2 = transmit count, 3 = receive count. Control fields: bits [5:4] trigger code, bit 3 modem enable, bit 2 transmit clear, bit 1 receive clear, bit 0 loopback. Status fields: bit 0 transmit flag, bit 1 transmit overflow, bit 2 receive overflow. Counts read zero-extended. Popped bytes appear on the queue output in the cycle after the accepted pop.

Top module: `sfifo_ctl`

## Requirements
- R1: After reset the control register reads 0, the status register reads 1 (flag set, no overflow), both counts read 0 and `sio_rts` is 0.
- R2: Bytes leave each queue in the order they entered. The count equals accepted pushes minus accepted pops. A popped byte appears on `tx_q`/`rx_q` one cycle after the accepted pop.
- R3: A push into a full queue (count = DEPTH = 64) is dropped and sets that queue's sticky overflow bit (status bit 1 for transmit, bit 2 for receive). Writing 0 to that bit at the status address clears it, and writing 1 leaves it unchanged.
- R4: A pop from an empty queue is refused. The `*_ready` output is 0, the count stays 0, and the queue output keeps the last popped byte.
- R5: Trigger code 00 selects level 32, 01 selects 16, 10 selects 2 and 11 selects 0. The status flag is set on the clock after the transmit count is at or below the selected level.
- R6: The status flag is sticky. A write of 0 to status bit 0 clears it only if status was read while the flag was 1 since the last status write, and only while the count is above the level.
- R7: While a clear bit is 1 (control bit 2 for transmit, bit 1 for receive), that count reads 0 and pushes to that queue are dropped. Once the bit is released, the queue works normally from empty.
- R8: With modem enable (control bit 3) at 0, `sio_cts` has no effect, `tx_ready` depends only on queue content, and `sio_rts` stays 0.
- R9: With modem enable at 1, `tx_ready` is 0 and transmit pops are refused while `sio_cts` is 1. `sio_rts` is 1 exactly when the receive queue has fewer than 2 free slots.
- R10: With loopback (control bit 0) at 1, `ser_rx_bit` follows `ser_tx_bit`, `sio_txd` is held at 1 and `sio_rxd` is ignored. With modem enable also at 1, the internal clear-to-send follows request-to-send and `sio_cts` is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_re | input | 1 | Register read strobe (marks a status read) |
| cfg_addr | input | 2 | Register address |
| cfg_wdata | input | 8 | Register write data |
| cfg_rdata | output | 8 | Register read data for `cfg_addr` |
| tx_push | input | 1 | Software push into the transmit queue |
| tx_data | input | 8 | Byte to push into the transmit queue |
| tx_pop | input | 1 | Serialiser request for the next byte |
| tx_ready | output | 1 | Transmit pop would be accepted |
| tx_q | output | 8 | Last byte popped from the transmit queue |
| rx_push | input | 1 | Deserialiser push into the receive queue |
| rx_data | input | 8 | Byte to push into the receive queue |
| rx_pop | input | 1 | Software pop from the receive queue |
| rx_ready | output | 1 | Receive pop would be accepted |
| rx_q | output | 8 | Last byte popped from the receive queue |
| ser_tx_bit | input | 1 | Serial output of the bit engine |
| sio_txd | output | 1 | Transmit data line |
| sio_rxd | input | 1 | Receive data line |
| ser_rx_bit | output | 1 | Serial input to the bit engine |
| sio_rts | output | 1 | Request-to-send line, 1 = stop sending |
| sio_cts | input | 1 | Clear-to-send line, 1 = hold transmission |

## Verification
The hardest state to reach is a drop of the sticky transmit flag. It needs a status read while the flag is 1, then a status write of 0, all while the count sits above a level that the bench has just moved. The stimulus climbs above each trigger level, switches codes, and tries the write both with and without the read. The other hard case is the loopback stall, where request-to-send must block transmission. The bench fills the receive queue to within one slot of full with modem control on, then frees two slots and watches the transmit side resume.

// File: rtl/sfifo_pkg.sv
package sfifo_pkg;

   localparam logic [1:0] ADDR_CTRL  = 2'd0;
   localparam logic [1:0] ADDR_STAT  = 2'd1;
   localparam logic [1:0] ADDR_TXCNT = 2'd2;
   localparam logic [1:0] ADDR_RXCNT = 2'd3;

   localparam int STAT_FLAG  = 0;
   localparam int STAT_TXOVF = 1;
   localparam int STAT_RXOVF = 2;

   localparam int CH_TX = 0;
   localparam int CH_RX = 1;
   localparam int N_CH  = 2;

   // field order mirrors control bits [5:0]
   typedef struct packed {
      logic [1:0] trig;
      logic       modem;
      logic       tx_clr;
      logic       rx_clr;
      logic       loop;
   } ctrl_t;

   localparam int CTRL_W = $bits(ctrl_t);

   function automatic int unsigned trig_level(input logic [1:0] code, input int unsigned depth);
      case (code)
         2'b00:   return depth / 2;
         2'b01:   return depth / 4;
         2'b10:   return 2;
         default: return 0;
      endcase
   endfunction

endpackage

// File: rtl/sfifo_store.sv
module sfifo_store #(
   parameter int DEPTH = 64,
   parameter int WIDTH = 8,
   localparam int PW = $clog2(DEPTH),
   localparam int CW = PW + 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             push,
   input  logic [WIDTH-1:0] din,
   input  logic             pop,
   input  logic             allow,
   output logic [WIDTH-1:0] q,
   output logic [CW-1:0]    cnt,
   output logic             ovf_hit,
   output logic             can_pop
);

   if (DEPTH < 8 || (1 << PW) != DEPTH) begin : g_bad_depth
      $error("sfifo_store: DEPTH must be a power of two and at least 8");
   end
   if (WIDTH < 1) begin : g_bad_width
      $error("sfifo_store: WIDTH must be positive");
   end

   logic [WIDTH-1:0] mem [DEPTH];
   logic [PW-1:0]    wp, rp;
   logic             full, empty, do_push, do_pop;

   assign full    = (cnt == CW'(DEPTH));
   assign empty   = (cnt == '0);
   assign do_push = push && !full && !clr;
   assign do_pop  = pop && allow && !empty && !clr;
   assign can_pop = allow && !empty && !clr;
   assign ovf_hit = push && full && !clr;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wp  <= '0;
         rp  <= '0;
         cnt <= '0;
         q   <= '0;
      end else if (clr) begin
         wp  <= '0;
         rp  <= '0;
         cnt <= '0;
      end else begin
         if (do_push) wp <= wp + 1'b1;
         if (do_pop) begin
            rp <= rp + 1'b1;
            q  <= mem[rp];
         end
         cnt <= cnt + CW'(do_push) - CW'(do_pop);
      end
   end

   always_ff @(posedge clk) begin
      if (do_push) mem[wp] <= din;
   end

   p_clear_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> (cnt == '0));

   p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
      cnt <= CW'(DEPTH));

   p_full_push_dropped_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (ovf_hit && !pop) |=> $stable(cnt));

   p_empty_pop_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (pop && empty && !push) |=> ($stable(q) && cnt == '0));

endmodule

// File: rtl/sfifo_trig.sv
module sfifo_trig
   import sfifo_pkg::*;
#(
   parameter int DEPTH = 64,
   localparam int CW = $clog2(DEPTH) + 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [1:0]    code,
   input  logic [CW-1:0] cnt,
   input  logic          st_rd,
   input  logic          st_wr,
   input  logic          st_wbit,
   output logic          flag
);

   if (DEPTH / 4 <= 2) begin : g_bad_levels
      $error("sfifo_trig: DEPTH too small for distinct trigger levels");
   end

   logic [CW-1:0] level;
   logic          at_or_below;
   logic          seen;

   assign level       = CW'(trig_level(code, DEPTH));
   assign at_or_below = (cnt <= level);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         flag <= 1'b1;
         seen <= 1'b0;
      end else begin
         if (at_or_below)
            flag <= 1'b1;
         else if (st_wr && !st_wbit && seen)
            flag <= 1'b0;

         if (st_wr)
            seen <= 1'b0;
         else if (st_rd && flag)
            seen <= 1'b1;
      end
   end

   p_level_sets_r5: assert property (@(posedge clk) disable iff (!rst_n)
      at_or_below |=> flag);

   p_flag_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (flag && !(st_wr && !st_wbit)) |=> flag);

endmodule

// File: rtl/sfifo_modem.sv
module sfifo_modem #(
   parameter int DEPTH  = 64,
   parameter int MARGIN = 2,
   localparam int CW = $clog2(DEPTH) + 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          modem_en,
   input  logic          loop,
   input  logic [CW-1:0] rx_cnt,
   input  logic          cts_pin,
   input  logic          tx_bit,
   input  logic          rxd_pin,
   output logic          rts_pin,
   output logic          txd_pin,
   output logic          rx_bit,
   output logic          tx_allow
);

   if (MARGIN < 1 || MARGIN > DEPTH) begin : g_bad_margin
      $error("sfifo_modem: MARGIN out of range");
   end

   logic [CW-1:0] rx_free;
   logic          rts_int, cts_eff;

   assign rx_free  = CW'(DEPTH) - rx_cnt;
   assign rts_int  = modem_en && (rx_free < CW'(MARGIN));
   assign cts_eff  = modem_en && (loop ? rts_int : cts_pin);
   assign tx_allow = !cts_eff;
   assign rts_pin  = rts_int;
   assign txd_pin  = loop ? 1'b1 : tx_bit;
   assign rx_bit   = loop ? tx_bit : rxd_pin;

   p_modem_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !modem_en |-> (!rts_pin && tx_allow));

   p_rts_room_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_cnt <= CW'(DEPTH - MARGIN)) |-> !rts_pin);

   p_loop_flow_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (loop && modem_en) |-> (tx_allow == !rts_pin));

endmodule

// File: rtl/sfifo_ctl.sv
module sfifo_ctl
   import sfifo_pkg::*;
#(
   parameter int DEPTH      = 64,
   parameter int DATA_W     = 8,
   parameter int RTS_MARGIN = 2,
   localparam int CW  = $clog2(DEPTH) + 1,
   localparam int REG_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_we,
   input  logic              cfg_re,
   input  logic [1:0]        cfg_addr,
   input  logic [REG_W-1:0]  cfg_wdata,
   output logic [REG_W-1:0]  cfg_rdata,
   input  logic              tx_push,
   input  logic [DATA_W-1:0] tx_data,
   input  logic              tx_pop,
   output logic              tx_ready,
   output logic [DATA_W-1:0] tx_q,
   input  logic              rx_push,
   input  logic [DATA_W-1:0] rx_data,
   input  logic              rx_pop,
   output logic              rx_ready,
   output logic [DATA_W-1:0] rx_q,
   input  logic              ser_tx_bit,
   output logic              sio_txd,
   input  logic              sio_rxd,
   output logic              ser_rx_bit,
   output logic              sio_rts,
   input  logic              sio_cts
);

   if (CW > REG_W) begin : g_bad_cnt_w
      $error("sfifo_ctl: count does not fit the register width");
   end
   if (CTRL_W > REG_W) begin : g_bad_ctrl_w
      $error("sfifo_ctl: control fields do not fit the register width");
   end

   ctrl_t ctrl;
   logic  tx_ovf, rx_ovf, tx_flag;
   logic  wr_ctrl, wr_stat, rd_stat, tx_allow;
   logic  unused_wbits;

   assign wr_ctrl      = cfg_we && (cfg_addr == ADDR_CTRL);
   assign wr_stat      = cfg_we && (cfg_addr == ADDR_STAT);
   assign rd_stat      = cfg_re && (cfg_addr == ADDR_STAT);
   assign unused_wbits = ^cfg_wdata[REG_W-1:CTRL_W];

   logic [N_CH-1:0]   f_push, f_pop, f_allow, f_clr, f_ovf, f_can;
   logic [DATA_W-1:0] f_din [N_CH];
   logic [DATA_W-1:0] f_q   [N_CH];
   logic [CW-1:0]     f_cnt [N_CH];

   assign f_push  = {rx_push, tx_push};
   assign f_pop   = {rx_pop, tx_pop};
   assign f_allow = {1'b1, tx_allow};
   assign f_clr   = {ctrl.rx_clr, ctrl.tx_clr};
   assign f_din[CH_TX] = tx_data;
   assign f_din[CH_RX] = rx_data;

   for (genvar c = 0; c < N_CH; c++) begin : g_fifo
      sfifo_store #(.DEPTH(DEPTH), .WIDTH(DATA_W)) u_store (
         .clk     (clk),
         .rst_n   (rst_n),
         .clr     (f_clr[c]),
         .push    (f_push[c]),
         .din     (f_din[c]),
         .pop     (f_pop[c]),
         .allow   (f_allow[c]),
         .q       (f_q[c]),
         .cnt     (f_cnt[c]),
         .ovf_hit (f_ovf[c]),
         .can_pop (f_can[c])
      );
   end

   assign tx_q     = f_q[CH_TX];
   assign rx_q     = f_q[CH_RX];
   assign tx_ready = f_can[CH_TX];
   assign rx_ready = f_can[CH_RX];

   sfifo_trig #(.DEPTH(DEPTH)) u_trig (
      .clk     (clk),
      .rst_n   (rst_n),
      .code    (ctrl.trig),
      .cnt     (f_cnt[CH_TX]),
      .st_rd   (rd_stat),
      .st_wr   (wr_stat),
      .st_wbit (cfg_wdata[STAT_FLAG]),
      .flag    (tx_flag)
   );

   sfifo_modem #(.DEPTH(DEPTH), .MARGIN(RTS_MARGIN)) u_modem (
      .clk      (clk),
      .rst_n    (rst_n),
      .modem_en (ctrl.modem),
      .loop     (ctrl.loop),
      .rx_cnt   (f_cnt[CH_RX]),
      .cts_pin  (sio_cts),
      .tx_bit   (ser_tx_bit),
      .rxd_pin  (sio_rxd),
      .rts_pin  (sio_rts),
      .txd_pin  (sio_txd),
      .rx_bit   (ser_rx_bit),
      .tx_allow (tx_allow)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl   <= '0;
         tx_ovf <= 1'b0;
         rx_ovf <= 1'b0;
      end else begin
         if (wr_ctrl) ctrl <= ctrl_t'(cfg_wdata[CTRL_W-1:0]);

         if (f_ovf[CH_TX])
            tx_ovf <= 1'b1;
         else if (wr_stat && !cfg_wdata[STAT_TXOVF])
            tx_ovf <= 1'b0;

         if (f_ovf[CH_RX])
            rx_ovf <= 1'b1;
         else if (wr_stat && !cfg_wdata[STAT_RXOVF])
            rx_ovf <= 1'b0;
      end
   end

   always_comb begin
      cfg_rdata = '0;
      case (cfg_addr)
         ADDR_CTRL:  cfg_rdata[CTRL_W-1:0] = ctrl;
         ADDR_STAT: begin
            cfg_rdata[STAT_FLAG]  = tx_flag;
            cfg_rdata[STAT_TXOVF] = tx_ovf;
            cfg_rdata[STAT_RXOVF] = rx_ovf;
         end
         ADDR_TXCNT: cfg_rdata[CW-1:0] = f_cnt[CH_TX];
         default:    cfg_rdata[CW-1:0] = f_cnt[CH_RX];
      endcase
   end

   p_tx_ovf_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_ovf && !(wr_stat && !cfg_wdata[STAT_TXOVF])) |=> tx_ovf);

   p_rx_ovf_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_ovf && !(wr_stat && !cfg_wdata[STAT_RXOVF])) |=> rx_ovf);

   p_clear_blocks_pop_r7: assert property (@(posedge clk) disable iff (!rst_n)
      ctrl.tx_clr |-> !tx_ready);

endmodule

// File: tb/sfifo_ctl_test.sv
`timescale 1ns/1ps
module sfifo_ctl_test;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       cfg_we = 1'b0, cfg_re = 1'b0;
   logic [1:0] cfg_addr = '0;
   logic [7:0] cfg_wdata = '0, cfg_rdata;
   logic       tx_push = 1'b0, tx_pop = 1'b0, tx_ready;
   logic [7:0] tx_data = '0, tx_q;
   logic       rx_push = 1'b0, rx_pop = 1'b0, rx_ready;
   logic [7:0] rx_data = '0, rx_q;
   logic       ser_tx_bit = 1'b1, sio_txd, sio_rxd = 1'b1, ser_rx_bit;
   logic       sio_rts, sio_cts = 1'b0;

   always #2.5 clk = ~clk;

   sfifo_ctl uut (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_re(cfg_re),
      .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
      .tx_push(tx_push), .tx_data(tx_data), .tx_pop(tx_pop),
      .tx_ready(tx_ready), .tx_q(tx_q),
      .rx_push(rx_push), .rx_data(rx_data), .rx_pop(rx_pop),
      .rx_ready(rx_ready), .rx_q(rx_q),
      .ser_tx_bit(ser_tx_bit), .sio_txd(sio_txd), .sio_rxd(sio_rxd),
      .ser_rx_bit(ser_rx_bit), .sio_rts(sio_rts), .sio_cts(sio_cts)
   );

   int n_chk = 0;
   int n_err = 0;
   logic [7:0] exp_tx [$];
   logic [7:0] exp_rx [$];
   logic [7:0] v;

   task automatic ceq(input string req, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_err++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic summary();
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
   endtask

   // scoreboard monitor: a pop accepted at an edge is compared at the next low phase
   logic mon_tx = 1'b0, mon_rx = 1'b0;
   always @(posedge clk) begin
      mon_tx <= tx_pop && tx_ready;
      mon_rx <= rx_pop && rx_ready;
   end
   always @(negedge clk) begin
      if (mon_tx) begin
         if (exp_tx.size() == 0) ceq("R2 tx pop with empty scoreboard", 1, 0);
         else ceq("R2 tx byte order", tx_q, exp_tx.pop_front());
      end
      if (mon_rx) begin
         if (exp_rx.size() == 0) ceq("R2 rx pop with empty scoreboard", 1, 0);
         else ceq("R2 rx byte order", rx_q, exp_rx.pop_front());
      end
   end

   task automatic step();
      @(posedge clk);
      #1;
   endtask

   task automatic low();
      @(negedge clk);
   endtask

   task automatic wr(input logic [1:0] a, input logic [7:0] d);
      cfg_addr = a; cfg_wdata = d; cfg_we = 1'b1;
      step();
      cfg_we = 1'b0;
   endtask

   task automatic rd(input logic [1:0] a, output logic [7:0] d);
      cfg_addr = a; cfg_re = 1'b1;
      low();
      d = cfg_rdata;
      step();
      cfg_re = 1'b0;
   endtask

   task automatic txpush(input logic [7:0] d, input bit taken);
      tx_data = d; tx_push = 1'b1;
      if (taken) exp_tx.push_back(d);
      step();
      tx_push = 1'b0;
   endtask

   task automatic rxpush(input logic [7:0] d, input bit taken);
      rx_data = d; rx_push = 1'b1;
      if (taken) exp_rx.push_back(d);
      step();
      rx_push = 1'b0;
   endtask

   task automatic txpop();
      tx_pop = 1'b1;
      step();
      tx_pop = 1'b0;
   endtask

   task automatic rxpop();
      rx_pop = 1'b1;
      step();
      rx_pop = 1'b0;
   endtask

   initial begin
      #(5.0 * 200000);
      n_chk++;
      n_err++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      step();

      // R1 reset state
      rd(2'd0, v); ceq("R1 control after reset", v, 0);
      rd(2'd1, v); ceq("R1 status after reset", v, 1);
      rd(2'd2, v); ceq("R1 tx count after reset", v, 0);
      rd(2'd3, v); ceq("R1 rx count after reset", v, 0);
      low(); ceq("R1 rts after reset", sio_rts, 0); step();

      // R2 / R8: ordering with modem control off and cts held high
      sio_cts = 1'b1;
      for (int i = 0; i < 5; i++) txpush(8'hA0 + 8'(i), 1);
      rd(2'd2, v); ceq("R2 tx count after 5 pushes", v, 5);
      low(); ceq("R8 tx_ready ignores cts when modem off", tx_ready, 1); step();
      for (int i = 0; i < 5; i++) txpop();
      step();
      rd(2'd2, v); ceq("R2 tx count after draining", v, 0);
      ceq("R2 tx scoreboard drained", exp_tx.size(), 0);

      // R4 empty pop
      low(); ceq("R4 tx_ready low when empty", tx_ready, 0); step();
      txpop();
      low(); ceq("R4 tx_q keeps last byte", tx_q, 8'hA4); step();
      rd(2'd2, v); ceq("R4 tx count stays 0", v, 0);
      sio_cts = 1'b0;

      // R5 / R6 trigger levels and sticky flag
      for (int i = 0; i < 33; i++) txpush(8'(i), 1);
      step();
      rd(2'd1, v); ceq("R6 flag sticky above level 32", v[0], 1);
      wr(2'd1, 8'h00);
      rd(2'd1, v); ceq("R6 read then write 0 clears flag", v[0], 0);
      txpop();
      step();
      rd(2'd1, v); ceq("R5 code 00 sets flag at count 32", v[0], 1);
      wr(2'd0, 8'h20);
      rd(2'd1, v); ceq("R6 flag stays after code change", v[0], 1);
      wr(2'd1, 8'h00);
      step();
      rd(2'd1, v); ceq("R5 code 10 level 2 leaves flag clear at 32", v[0], 0);
      wr(2'd0, 8'h00);
      step();
      wr(2'd0, 8'h10);
      step();
      wr(2'd1, 8'h00);
      step();
      rd(2'd1, v); ceq("R6 write 0 without prior read keeps flag", v[0], 1);
      wr(2'd1, 8'h00);
      step();
      rd(2'd1, v); ceq("R5 code 01 level 16 allows clear at 32", v[0], 0);

      // R3 transmit overflow
      for (int i = 0; i < 32; i++) txpush(8'h40 + 8'(i), 1);
      rd(2'd2, v); ceq("R3 tx count full", v, 64);
      txpush(8'hEE, 0);
      rd(2'd2, v); ceq("R3 full push dropped", v, 64);
      rd(2'd1, v); ceq("R3 tx overflow set", v[1], 1);
      step();
      rd(2'd1, v); ceq("R3 tx overflow sticky", v[1], 1);
      wr(2'd1, 8'h05);
      rd(2'd1, v); ceq("R3 tx overflow cleared by 0", v[1], 0);
      for (int i = 0; i < 3; i++) txpop();
      step();
      rd(2'd2, v); ceq("R2 tx count 61", v, 61);

      // R7 transmit clear
      wr(2'd0, 8'h14);
      step();
      rd(2'd2, v); ceq("R7 tx count forced 0", v, 0);
      txpush(8'h55, 0);
      rd(2'd2, v); ceq("R7 push dropped while clearing", v, 0);
      exp_tx.delete();
      wr(2'd0, 8'h30);
      txpush(8'h11, 1);
      txpush(8'h22, 1);
      rd(2'd2, v); ceq("R7 tx works after release", v, 2);
      rd(2'd1, v); ceq("R5 flag set while count was 0", v[0], 1);
      wr(2'd1, 8'h06);
      rd(2'd1, v); ceq("R5 code 11 clear at count 2", v[0], 0);
      txpop();
      step();
      rd(2'd1, v); ceq("R5 code 11 no flag at count 1", v[0], 0);
      txpop();
      step();
      rd(2'd1, v); ceq("R5 code 11 flag at count 0", v[0], 1);

      // R2 receive ordering
      for (int i = 0; i < 4; i++) rxpush(8'hC0 + 8'(i), 1);
      rd(2'd3, v); ceq("R2 rx count 4", v, 4);
      for (int i = 0; i < 4; i++) rxpop();
      step();
      ceq("R2 rx scoreboard drained", exp_rx.size(), 0);

      // R3 receive overflow, R8 rts idle, R7 receive clear
      for (int i = 0; i < 64; i++) rxpush(8'(i), 1);
      rxpush(8'hFF, 0);
      rd(2'd3, v); ceq("R3 rx count stays 64", v, 64);
      rd(2'd1, v); ceq("R3 rx overflow set", v[2], 1);
      low(); ceq("R8 rts low with modem off", sio_rts, 0); step();
      wr(2'd0, 8'h32);
      step();
      rd(2'd3, v); ceq("R7 rx count forced 0", v, 0);
      rxpush(8'h99, 0);
      rd(2'd3, v); ceq("R7 rx push dropped while clearing", v, 0);
      exp_rx.delete();
      wr(2'd0, 8'h30);
      wr(2'd1, 8'h03);
      rd(2'd1, v); ceq("R3 rx overflow cleared", v[2], 0);

      // R9 modem control
      wr(2'd0, 8'h38);
      for (int i = 0; i < 62; i++) rxpush(8'(i), 1);
      low(); ceq("R9 rts low with 2 free", sio_rts, 0); step();
      rxpush(8'd62, 1);
      low(); ceq("R9 rts high with 1 free", sio_rts, 1); step();
      txpush(8'h77, 1);
      sio_cts = 1'b1;
      low(); ceq("R9 tx_ready low while cts high", tx_ready, 0); step();
      txpop();
      rd(2'd2, v); ceq("R9 pop refused while cts high", v, 1);
      sio_cts = 1'b0;
      low(); ceq("R9 tx_ready back with cts low", tx_ready, 1); step();
      txpop();
      step();

      // R10 loopback
      wr(2'd0, 8'h39);
      ser_tx_bit = 1'b0; sio_rxd = 1'b1;
      low();
      ceq("R10 rx bit follows tx bit", ser_rx_bit, 0);
      ceq("R10 txd held high", sio_txd, 1);
      step();
      ser_tx_bit = 1'b1; sio_rxd = 1'b0;
      low(); ceq("R10 rxd pin ignored", ser_rx_bit, 1); step();
      txpush(8'h78, 1);
      low(); ceq("R10 rts blocks tx in loopback", tx_ready, 0); step();
      rxpop();
      rxpop();
      sio_cts = 1'b1;
      low(); ceq("R10 tx resumes, cts pin ignored", tx_ready, 1); step();
      txpop();
      step();
      sio_cts = 1'b0;
      wr(2'd0, 8'h30);
      ser_tx_bit = 1'b0; sio_rxd = 1'b0;
      low();
      ceq("R10 loop off: rx bit from pin", ser_rx_bit, 0);
      ceq("R10 loop off: txd from engine", sio_txd, 0);
      step();
      ceq("R2 tx scoreboard empty at end", exp_tx.size(), 0);

      summary();
      $finish;
   end

endmodule